// File: doc/BRIEF.md
# Extended-Dividend Word Divider

This block is a multi-cycle integer divider for 32-bit divide operations whose 64-bit dividend is built from two sources. A 32-bit auxiliary word forms the upper half, and the low 32 bits of the first operand form the lower half. The divisor is either the low word of the second operand or a 13-bit immediate that is sign-extended to 32 bits. Signed and unsigned division are both supported.

A quotient that does not fit in 32 bits is not wrapped. It is clamped to a fixed value, and the clamp is reported on an overflow flag. A zero divisor raises a trap, and in that case the destination value is left unchanged.

The issuing pipeline presents a one-cycle start pulse together with its operands. It then waits for a one-cycle done pulse, which carries the 64-bit destination value. When the condition-code select was set, the done pulse also carries a set of condition codes for the 32-bit result.

Top module: `yext_divider`

## Requirements
- R1: The dividend is the concatenation {y_i, op1_i[31:0]}, with y_i in the upper half. op1_i[63:32] has no effect on any output.
- R2: When use_imm_i is 1, the divisor is imm_i sign-extended from bit 12 to 32 bits. When use_imm_i is 0, the divisor is op2_i[31:0], and op2_i[63:32] has no effect.
- R3: Unsigned mode (signed_i = 0): the dividend and divisor are unsigned. When the quotient fits in 32 bits, result_o is that quotient zero-extended to 64 bits.
- R4: Unsigned mode: when any quotient bit above bit 31 is set, result_o is 0x00000000FFFFFFFF and the overflow condition holds.
- R5: Signed mode (signed_i = 1): the dividend and divisor are two's complement. The quotient is truncated toward zero. When it lies in [-2^31, 2^31-1], result_o is that quotient sign-extended to 64 bits.
- R6: Signed mode: a quotient above 2^31-1 gives result_o = 0x000000007FFFFFFF. A quotient below -2^31 gives result_o = 0xFFFFFFFF80000000. Both cases set the overflow condition.
- R7: A zero divisor raises done_o and div_zero_o together for one cycle, in the cycle after start_i is sampled. In that case result_o keeps its previous value and cc_wr_o stays 0.
- R8: For a non-zero divisor, done_o rises after the 66th rising edge following the edge that samples start_i. It stays high for exactly one cycle, with div_zero_o at 0.
- R9: A start_i pulse that arrives while a division is in progress is ignored. The running division completes with its own operands and its own latency.
- R10: When setcc_i was 1 at start and no trap occurred, cc_wr_o is 1 together with done_o. The flags are then cc_n_o = result_o[31], cc_z_o = (result_o[31:0] == 0), cc_v_o = the overflow condition, and cc_c_o = 0. When setcc_i was 0, cc_wr_o stays 0.
- R11: After reset, done_o, div_zero_o and cc_wr_o are 0, and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a division |
| signed_i | input | 1 | 1 = signed division, 0 = unsigned |
| setcc_i | input | 1 | 1 = produce condition codes with the result |
| use_imm_i | input | 1 | 1 = divisor from imm_i, 0 = divisor from op2_i |
| y_i | input | 32 | Upper half of the dividend |
| op1_i | input | 64 | First operand; the low word is the lower half of the dividend |
| op2_i | input | 64 | Second operand; the low word is the register divisor |
| imm_i | input | 13 | Signed immediate divisor |
| result_o | output | 64 | Destination value, valid while done_o is 1 |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Divide-by-zero trap, asserted together with done_o |
| cc_wr_o | output | 1 | Condition codes valid and to be written |
| cc_n_o | output | 1 | Negative flag of the 32-bit result |
| cc_z_o | output | 1 | Zero flag of the 32-bit result |
| cc_v_o | output | 1 | Overflow (saturation) flag |
| cc_c_o | output | 1 | Carry flag, always cleared on write |

## Verification
The boundary quotients are the hardest cases to reach. These are exactly -2^31, which is legal, one step beyond it, which underflows, and 2^31 in signed mode, which overflows. Random operands almost never land on them, because they require a particular dividend for a particular divisor.

The stimulus therefore builds these dividends on purpose. It sweeps a grid of edge dividends, with the auxiliary word at all-zeros, all-ones or sign-boundary values, against edge divisors such as 1, -1, 2, -2 and the extreme magnitudes. The grid runs in both modes.

A second start pulse is injected mid-run to reach the ignore-while-busy case.

// File: rtl/yext_divider_pkg.sv
// Shared types for the extended-dividend divider.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package yext_divider_pkg;

    // Control sequencer states: accept, prepare magnitudes, iterate, finalise
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_RUN    = 2'd2,
        ST_FINISH = 2'd3
    } yd_state_e;

    // Condition codes produced for the 32-bit result
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } yd_cc_t;

endpackage

// File: rtl/yd_divisor_sel.sv
// Divisor selection: picks the register low word or the sign-extended
// immediate, and flags a zero divisor.
// Assumes: WORD_W > IMM_W.
module yd_divisor_sel #(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 13
) (
    input  logic              use_imm_i,
    input  logic [WORD_W-1:0] reg_lo_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [WORD_W-1:0] dvs_o,
    output logic              is_zero_o
);
    localparam int EXT_W = WORD_W - IMM_W;

    // Select the divisor source, sign-extending the immediate
    always_comb begin
        if (use_imm_i) dvs_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        else           dvs_o = reg_lo_i;
        is_zero_o = (dvs_o == '0);
    end
endmodule

// File: rtl/yd_magnitude.sv
// Operand conditioning: forms the double-width dividend from the upper
// word and the low word, converts both operands to magnitudes in signed
// mode, and reports whether the quotient must be negated.
// Assumes: the most negative dividend magnitude (2^(2W-1)) fits unsigned.
module yd_magnitude #(
    parameter int WORD_W = 32
) (
    input  logic                signed_i,
    input  logic [WORD_W-1:0]   hi_i,
    input  logic [WORD_W-1:0]   lo_i,
    input  logic [WORD_W-1:0]   dvs_i,
    output logic [2*WORD_W-1:0] dvd_mag_o,
    output logic [WORD_W-1:0]   dvs_mag_o,
    output logic                neg_o
);
    localparam int DVD_W = 2 * WORD_W;

    logic [DVD_W-1:0] dvd_raw;
    logic             dvd_neg;
    logic             dvs_neg;

    // Build the dividend and take absolute values when signed
    always_comb begin
        dvd_raw   = {hi_i, lo_i};
        dvd_neg   = signed_i & dvd_raw[DVD_W-1];
        dvs_neg   = signed_i & dvs_i[WORD_W-1];
        dvd_mag_o = dvd_neg ? (~dvd_raw + 1'b1) : dvd_raw;
        dvs_mag_o = dvs_neg ? (~dvs_i + 1'b1) : dvs_i;
        neg_o     = dvd_neg ^ dvs_neg;
    end
endmodule

// File: rtl/yd_div_core.sv
// Radix-2 restoring divider datapath. A load pulse seeds the partial
// remainder and the quotient/dividend shift register. Each step pulse
// retires one quotient bit, most significant first.
// Assumes: the divisor is non-zero; the caller issues exactly DVD_W steps.
module yd_div_core #(
    parameter int DVD_W = 64,
    parameter int DVS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [DVD_W-1:0] dvd_i,
    input  logic [DVS_W-1:0] dvs_i,
    output logic [DVD_W-1:0] quo_o
);
    logic [DVS_W:0]   rem_q;
    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] dvs_q;
    logic [DVS_W:0]   shifted;
    logic [DVS_W+1:0] trial;

    // Shift in the next dividend bit and trial-subtract the divisor
    always_comb begin
        shifted = {rem_q[DVS_W-1:0], quo_q[DVD_W-1]};
        trial   = {1'b0, shifted} - {2'b00, dvs_q};
    end

    // Hold remainder, quotient and divisor across the iterations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= dvd_i;
            dvs_q <= dvs_i;
        end else if (step_i) begin
            if (!trial[DVS_W+1]) begin
                rem_q <= trial[DVS_W:0];
                quo_q <= {quo_q[DVD_W-2:0], 1'b1};
            end else begin
                rem_q <= shifted;
                quo_q <= {quo_q[DVD_W-2:0], 1'b0};
            end
        end
    end

    assign quo_o = quo_q;
endmodule

// File: rtl/yd_result_fix.sv
// Result finishing: applies the quotient sign, clamps out-of-range
// quotients to the fixed saturation values, and derives condition codes
// from the 32-bit result.
// Assumes: quo_mag_i is the unsigned magnitude of the true quotient.
module yd_result_fix
    import yext_divider_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                signed_i,
    input  logic                neg_i,
    input  logic [2*WORD_W-1:0] quo_mag_i,
    output logic [2*WORD_W-1:0] result_o,
    output yd_cc_t              cc_o
);
    localparam int RES_W = 2 * WORD_W;
    localparam logic [RES_W-1:0] U_SAT = {{WORD_W{1'b0}}, {WORD_W{1'b1}}};
    localparam logic [RES_W-1:0] P_SAT = {{(WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic [RES_W-1:0] N_SAT = {{(WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

    logic ovf;

    // Range check and clamp per mode and sign
    always_comb begin
        if (!signed_i) begin
            ovf      = |quo_mag_i[RES_W-1:WORD_W];
            result_o = ovf ? U_SAT : {{WORD_W{1'b0}}, quo_mag_i[WORD_W-1:0]};
        end else if (!neg_i) begin
            ovf      = |quo_mag_i[RES_W-1:WORD_W-1];
            result_o = ovf ? P_SAT : quo_mag_i;
        end else begin
            ovf      = (|quo_mag_i[RES_W-1:WORD_W]) ||
                       (quo_mag_i[WORD_W-1] && (|quo_mag_i[WORD_W-2:0]));
            result_o = ovf ? N_SAT : (~quo_mag_i + 1'b1);
        end
    end

    // Condition codes of the low word
    always_comb begin
        cc_o.n = result_o[WORD_W-1];
        cc_o.z = (result_o[WORD_W-1:0] == '0);
        cc_o.v = ovf;
        cc_o.c = 1'b0;
    end
endmodule

// File: rtl/yext_divider.sv
// Extended-dividend word divider top. It accepts a start pulse when idle,
// traps at once on a zero divisor, and otherwise runs setup, 2*WORD_W
// restoring steps and a finish cycle before pulsing done.
// Assumes: start_i is ignored while a division is in flight.
module yext_divider
    import yext_divider_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                signed_i,
    input  logic                setcc_i,
    input  logic                use_imm_i,
    input  logic [WORD_W-1:0]   y_i,
    input  logic [2*WORD_W-1:0] op1_i,
    input  logic [2*WORD_W-1:0] op2_i,
    input  logic [IMM_W-1:0]    imm_i,
    output logic [2*WORD_W-1:0] result_o,
    output logic                done_o,
    output logic                div_zero_o,
    output logic                cc_wr_o,
    output logic                cc_n_o,
    output logic                cc_z_o,
    output logic                cc_v_o,
    output logic                cc_c_o
);
    localparam int DVD_W = 2 * WORD_W;
    localparam int ITER  = DVD_W;
    localparam int CNT_W = $clog2(ITER);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(ITER - 1);

    yd_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              signed_q, setcc_q, neg_q;
    logic [WORD_W-1:0] y_q, lo_q, dvs_q;
    logic [DVD_W-1:0]  result_q;
    logic              done_q, dz_q, ccwr_q;
    yd_cc_t            cc_q;
    logic              busy_w;

    logic [WORD_W-1:0] sel_dvs;
    logic              sel_zero;
    logic [DVD_W-1:0]  dvd_mag;
    logic [WORD_W-1:0] dvs_mag;
    logic              neg_w;
    logic [DVD_W-1:0]  quo_mag;
    logic [DVD_W-1:0]  fix_res;
    yd_cc_t            fix_cc;
    logic              unused_hi;

    // Upper operand halves play no part in this operation
    assign unused_hi = ^{op1_i[DVD_W-1:WORD_W], op2_i[DVD_W-1:WORD_W]};
    assign busy_w    = (state_q != ST_IDLE);

    yd_divisor_sel #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_sel (
        .use_imm_i (use_imm_i),
        .reg_lo_i  (op2_i[WORD_W-1:0]),
        .imm_i     (imm_i),
        .dvs_o     (sel_dvs),
        .is_zero_o (sel_zero)
    );

    yd_magnitude #(.WORD_W(WORD_W)) u_mag (
        .signed_i  (signed_q),
        .hi_i      (y_q),
        .lo_i      (lo_q),
        .dvs_i     (dvs_q),
        .dvd_mag_o (dvd_mag),
        .dvs_mag_o (dvs_mag),
        .neg_o     (neg_w)
    );

    yd_div_core #(.DVD_W(DVD_W), .DVS_W(WORD_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (state_q == ST_SETUP),
        .step_i (state_q == ST_RUN),
        .dvd_i  (dvd_mag),
        .dvs_i  (dvs_mag),
        .quo_o  (quo_mag)
    );

    yd_result_fix #(.WORD_W(WORD_W)) u_fix (
        .signed_i  (signed_q),
        .neg_i     (neg_q),
        .quo_mag_i (quo_mag),
        .result_o  (fix_res),
        .cc_o      (fix_cc)
    );

    // Sequencer: capture operands, iterate, register the finished result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            signed_q <= 1'b0;
            setcc_q  <= 1'b0;
            neg_q    <= 1'b0;
            y_q      <= '0;
            lo_q     <= '0;
            dvs_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            dz_q     <= 1'b0;
            ccwr_q   <= 1'b0;
            cc_q     <= '0;
        end else begin
            done_q <= 1'b0;
            dz_q   <= 1'b0;
            ccwr_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        signed_q <= signed_i;
                        setcc_q  <= setcc_i;
                        y_q      <= y_i;
                        lo_q     <= op1_i[WORD_W-1:0];
                        dvs_q    <= sel_dvs;
                        if (sel_zero) begin
                            done_q <= 1'b1;
                            dz_q   <= 1'b1;
                        end else begin
                            state_q <= ST_SETUP;
                        end
                    end
                end
                ST_SETUP: begin
                    neg_q   <= neg_w;
                    cnt_q   <= '0;
                    state_q <= ST_RUN;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) state_q <= ST_FINISH;
                end
                ST_FINISH: begin
                    result_q <= fix_res;
                    cc_q     <= fix_cc;
                    ccwr_q   <= setcc_q;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign result_o   = result_q;
    assign done_o     = done_q;
    assign div_zero_o = dz_q;
    assign cc_wr_o    = ccwr_q;
    assign cc_n_o     = cc_q.n;
    assign cc_z_o     = cc_q.z;
    assign cc_v_o     = cc_q.v;
    assign cc_c_o     = cc_q.c;
endmodule

// File: rtl/yext_divider_chk.sv
// Protocol and result checker for yext_divider, attached by bind.
// Assumes: busy_i is high from the cycle after an accepted start until the
// cycle in which done rises.
module yext_divider_chk #(
    parameter int WORD_W = 32,
    parameter int ITER   = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy_i,
    input logic                done_o,
    input logic                div_zero_o,
    input logic                cc_wr_o,
    input logic                cc_v_o,
    input logic                cc_c_o,
    input logic [2*WORD_W-1:0] result_o
);
    localparam int BC_W = $clog2(ITER + 3);
    localparam logic [2*WORD_W-1:0] U_SAT = {{WORD_W{1'b0}}, {WORD_W{1'b1}}};
    localparam logic [2*WORD_W-1:0] P_SAT = {{(WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic [2*WORD_W-1:0] N_SAT = {{(WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

    logic [BC_W-1:0] busy_cnt;

    // Count consecutive busy cycles of the current division
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (busy_i) busy_cnt <= busy_cnt + 1'b1;
        else             busy_cnt <= '0;
    end

    // R7
    trap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> done_o);

    // R7
    trap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> $stable(result_o));

    // R10
    ccwr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_wr_o |-> (done_o && !div_zero_o && !cc_c_o));

    // R4 R6
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_wr_o && cc_v_o) |-> (result_o == U_SAT || result_o == P_SAT || result_o == N_SAT));

    // R8 R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o) |-> (busy_cnt == BC_W'(ITER + 2)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o) |=> (!done_o || div_zero_o));
endmodule

bind yext_divider yext_divider_chk #(.WORD_W(WORD_W), .ITER(ITER)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy_w),
    .done_o     (done_o),
    .div_zero_o (div_zero_o),
    .cc_wr_o    (cc_wr_o),
    .cc_v_o     (cc_v_o),
    .cc_c_o     (cc_c_o),
    .result_o   (result_o)
);

// File: tb/yext_divider_tb_top.sv
module yext_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, signed_i = 1'b0, setcc_i = 1'b0, use_imm_i = 1'b0;
    logic [31:0] y_i = '0;
    logic [63:0] op1_i = '0, op2_i = '0;
    logic [12:0] imm_i = '0;
    logic [63:0] result_o;
    logic        done_o, div_zero_o, cc_wr_o, cc_n_o, cc_z_o, cc_v_o, cc_c_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always #5 clk = ~clk;

    yext_divider dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .setcc_i(setcc_i), .use_imm_i(use_imm_i), .y_i(y_i), .op1_i(op1_i),
        .op2_i(op2_i), .imm_i(imm_i), .result_o(result_o), .done_o(done_o),
        .div_zero_o(div_zero_o), .cc_wr_o(cc_wr_o), .cc_n_o(cc_n_o),
        .cc_z_o(cc_z_o), .cc_v_o(cc_v_o), .cc_c_o(cc_c_o)
    );

    function automatic logic [63:0] next_rng(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference quotient and overflow from plain arithmetic
    task automatic model(input logic sgn, input logic [31:0] y, input logic [31:0] lo,
                         input logic [31:0] d, output logic [63:0] res, output logic ovf);
        logic [63:0] uq;
        logic signed [65:0] sd, sv, sq;
        if (!sgn) begin
            uq  = {y, lo} / {32'd0, d};
            ovf = |uq[63:32];
            res = ovf ? 64'h00000000FFFFFFFF : {32'd0, uq[31:0]};
        end else begin
            sd = {{2{y[31]}}, y, lo};
            sv = {{34{d[31]}}, d};
            sq = sd / sv;
            if (sq > 66'sd2147483647) begin
                ovf = 1'b1; res = 64'h000000007FFFFFFF;
            end else if (sq < -66'sd2147483648) begin
                ovf = 1'b1; res = 64'hFFFFFFFF80000000;
            end else begin
                ovf = 1'b0; res = sq[63:0];
            end
        end
    endtask

    task automatic issue(input logic sgn, input logic cc, input logic im,
                         input logic [31:0] y, input logic [63:0] o1,
                         input logic [63:0] o2, input logic [12:0] imm, output int lat);
        @(negedge clk);
        signed_i = sgn; setcc_i = cc; use_imm_i = im;
        y_i = y; op1_i = o1; op2_i = o2; imm_i = imm; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        op1_i = ~op1_i; op2_i = ~op2_i; y_i = ~y_i;
        lat = 1;
        while (!done_o && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Full check of one division with a non-zero divisor
    task automatic do_div(input string tag, input logic sgn, input logic cc, input logic im,
                          input logic [31:0] y, input logic [63:0] o1,
                          input logic [63:0] o2, input logic [12:0] imm);
        logic [31:0] d;
        logic [63:0] er;
        logic ev;
        int lat;
        d = im ? {{19{imm[12]}}, imm} : o2[31:0];
        model(sgn, y, o1[31:0], d, er, ev);
        issue(sgn, cc, im, y, o1, o2, imm, lat);
        chk({tag, " R8 latency"}, 72'(lat), 72'd67);
        chk({tag, " R3 R5 value"}, {8'd0, result_o}, {8'd0, er});
        if (cc)
            chk({tag, " R10 flags"}, 72'({div_zero_o, cc_wr_o, cc_n_o, cc_z_o, cc_v_o, cc_c_o}),
                72'({1'b0, 1'b1, er[31], er[31:0] == 32'd0, ev, 1'b0}));
        else
            chk({tag, " R10 no write"}, 72'({div_zero_o, cc_wr_o}), 72'd0);
        @(negedge clk);
        chk({tag, " R8 pulse"}, 72'(done_o), 72'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] ys[8];
        logic [31:0] los[4];
        logic [31:0] ds[10];
        logic [63:0] keep;
        int lat;

        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset", 72'({result_o, done_o, div_zero_o, cc_wr_o}), 72'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed
        do_div("R3 basic", 0, 1, 0, 32'd0, 64'd100, 64'd7, 13'd0);
        do_div("R1 upper op1 ignored", 0, 1, 0, 32'd1, 64'hDEADBEEF_00000000, 64'd2, 13'd0);
        do_div("R4 unsigned sat", 0, 1, 0, 32'd1, 64'd0, 64'd1, 13'd0);
        do_div("R5 neg/pos", 1, 1, 0, 32'hFFFFFFFF, 64'hFFFFFFF9, 64'd2, 13'd0);
        do_div("R5 pos/neg", 1, 1, 0, 32'd0, 64'd7, 64'hFFFFFFFE, 13'd0);
        do_div("R6 pos sat", 1, 1, 0, 32'd0, 64'h80000000, 64'd1, 13'd0);
        do_div("R6 exact min", 1, 1, 0, 32'hFFFFFFFF, 64'h80000000, 64'd1, 13'd0);
        do_div("R6 neg sat", 1, 1, 0, 32'hFFFFFFFF, 64'h7FFFFFFF, 64'd1, 13'd0);
        do_div("R6 min by -1", 1, 1, 0, 32'h80000000, 64'd0, 64'hFFFFFFFF, 13'd0);
        do_div("R2 imm unsigned", 0, 1, 1, 32'd5, 64'd9, 64'd3, 13'h1FFF);
        do_div("R2 imm signed", 1, 1, 1, 32'hFFFFFFFF, 64'hFFFFFF00, 64'd3, 13'h1FFD);
        do_div("R2 upper op2 ignored", 0, 1, 0, 32'd0, 64'd1000, 64'hFFFF0000_0000000A, 13'd0);
        do_div("R10 setcc off", 0, 0, 0, 32'd0, 64'd50, 64'd5, 13'd0);
        do_div("R10 zero flag", 0, 1, 0, 32'd0, 64'd3, 64'd5, 13'd0);

        // R7 traps: register divisor with nonzero upper half, then immediate zero
        keep = result_o;
        issue(0, 1, 0, 32'd3, 64'd9, 64'hFFFFFFFF_00000000, 13'd5, lat);
        chk("R7 trap latency", 72'(lat), 72'd1);
        chk("R7 trap outputs", {1'b0, div_zero_o, cc_wr_o, 5'd0, result_o}, {8'b01000000, keep});
        @(negedge clk);
        chk("R7 trap pulse", 72'({done_o, div_zero_o}), 72'd0);
        issue(1, 1, 1, 32'd3, 64'd9, 64'd4, 13'd0, lat);
        chk("R7 imm trap", {lat == 1, div_zero_o, cc_wr_o, 5'd0, result_o}, {8'b11000000, keep});

        // R9 start while busy is ignored
        @(negedge clk);
        signed_i = 0; setcc_i = 1; use_imm_i = 0;
        y_i = 32'd0; op1_i = 64'd1000; op2_i = 64'd10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        repeat (10) begin @(negedge clk); lat++; end
        op1_i = 64'd77; op2_i = 64'd0; start_i = 1'b1;
        @(negedge clk);
        lat++;
        start_i = 1'b0;
        while (!done_o && lat < 300) begin @(negedge clk); lat++; end
        chk("R9 busy start latency", 72'(lat), 72'd67);
        chk("R9 busy start result", {6'd0, div_zero_o, cc_wr_o, result_o}, {8'd1, 64'd100});
        repeat (3) @(negedge clk);
        chk("R9 no trailing run", 72'(done_o), 72'd0);

        // Edge sweep in both modes
        ys  = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h3, 32'h0000FFFF};
        los = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
        ds  = '{32'd1, 32'hFFFFFFFF, 32'd2, 32'hFFFFFFFE, 32'h7FFFFFFF, 32'h80000000,
                32'd3, 32'hFFFFFFFD, 32'h00010000, 32'h80000001};
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 4; b++)
                    for (int c = 0; c < 10; c++)
                        do_div("R5 R6 sweep", s[0], c[0], 0, ys[a], {32'hA5A5A5A5, los[b]},
                               {32'h5A5A5A5A, ds[c]}, 13'd0);

        // Pseudo-random mix including immediate divisors
        for (int k = 0; k < 600; k++) begin
            logic [63:0] r1, r2;
            rng = next_rng(rng); r1 = rng;
            rng = next_rng(rng); r2 = rng;
            if (r2[40:33] == 8'd0) r2[0] = 1'b1;
            if (r2[50:38] == 13'd0) r2[38] = 1'b1;
            do_div("R2 R3 random", r1[63], r2[63], r2[62], r1[2] ? r1[63:32] : {31'd0, r1[5]},
                   r1, {r2[63:41], (r2[4] ? r2[40:0] : {25'd0, r2[40:33] ^ 8'h00, 8'd0})},
                   r2[50:38]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule